// File: doc/BRIEF.md
# I2C Slave Address and General-Call Recognizer

This block sits behind a bit-level I2C shifter and watches the decoded event stream: start and stop events, completed bytes, and the falling SCL edge that ends the R/W bit. It decides whether the device is being addressed by comparing the received 7-bit address against a set of programmable slave IDs. For every byte it must answer, it produces a one-cycle ACK decision.

When general calls are enabled, it also accepts the reserved address zero with write direction. It then classifies the byte that follows. That byte may be a reset-and-reprogram command, a reprogram-only command, or a hardware general call. A hardware general call is detected by comparing the byte with an alternate ID value.

The outcome of a general call is held in a 2-bit status code until software clears it through a self-clearing clear request. The block also produces three single-cycle pulses: an interface-reset pulse, a stop interrupt, and a transmit-data request for read transfers.

Top module: `i2c_slave_recog`

## Requirements
- R1: An address byte whose bits [7:1] equal any slave ID and are nonzero is acknowledged (ack_vld=1, ack=1), and addressed goes to 1 one cycle after the byte strobe. Bit 0 is the R/W bit (1 = read). Slave ID k occupies slv_ids[7k+6:7k].
- R2: An address byte that matches no ID and is not an accepted general call gives ack_vld=1 with ack=0. addressed stays 0, and later data bytes give no ack_vld.
- R3: Byte 0x00 is acknowledged as a general call only when gc_en=1. Byte 0x01 (read direction) and byte 0x00 with gc_en=0 are not acknowledged.
- R4: After an accepted general call, a data byte 0x06 is acknowledged, sets gc_status to 2'b01, pulses iface_rst for one cycle, and returns the recognizer to idle, where bytes give no ack_vld.
- R5: After an accepted general call, a data byte 0x04 sets gc_status to 2'b10 without an iface_rst pulse. Later bytes up to the next start give no ack_vld.
- R6: With hwgc_en=1, a byte after a general call that equals alt_id sets gc_status to 2'b11. With hwgc_en=0 the same byte leaves gc_status unchanged.
- R7: stop_irq pulses one cycle after a stop event only if stop_irq_en=1 and an address was acknowledged since the last stop.
- R8: After an acknowledged read address, is_read=1, and the next rw_fall pulses tx_req one cycle later unless txreq_dis=1. No tx_req follows a write address.
- R9: A gc_clr pulse sets gc_clr_pend for one cycle. In the cycle after that, gc_status returns to 2'b00 and gc_clr_pend to 0. If a general-call classification falls in the same cycle as the pending clear, the new code is stored.
- R10: While slv_en=0, no byte is answered (ack_vld=0), and gc_status, stop_irq, iface_rst and tx_req are not changed by bus events.
- R11: Any start, including a repeated start, returns the recognizer to address wait. A stop returns it to idle, where bytes give no ack_vld.
- R12: After reset, all outputs are 0.
- R13: While addressed for write, each data byte gets ack_vld=1 and ack=1. While addressed for read, data bytes get no ack_vld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slv_en | input | 1 | Slave recognition enable |
| gc_en | input | 1 | General-call acceptance enable |
| hwgc_en | input | 1 | Hardware general-call compare enable |
| stop_irq_en | input | 1 | Stop interrupt enable |
| txreq_dis | input | 1 | Suppresses the transmit-data request |
| gc_clr | input | 1 | Request to clear the general-call status |
| slv_ids | input | NUM_IDS*7 | Packed programmable slave IDs, ID k in bits [7k+6:7k] |
| alt_id | input | 8 | Alternate ID for hardware general calls (LSB expected 1) |
| start_evt | input | 1 | Start or repeated-start event strobe |
| stop_evt | input | 1 | Stop event strobe |
| byte_vld | input | 1 | Received byte strobe |
| byte_data | input | 8 | Received byte |
| rw_fall | input | 1 | Falling SCL edge that ends the R/W bit |
| ack_vld | output | 1 | ACK decision valid for the last byte |
| ack | output | 1 | ACK (1) or NACK (0) |
| addressed | output | 1 | Device is selected by a slave ID |
| is_read | output | 1 | Selected transfer is a read |
| gc_status | output | 2 | 00 none, 01 reset, 10 reprogram, 11 hardware call |
| iface_rst | output | 1 | One-cycle interface reset pulse |
| stop_irq | output | 1 | One-cycle stop interrupt pulse |
| tx_req | output | 1 | One-cycle transmit-data request pulse |
| gc_clr_pend | output | 1 | Self-clearing clear request in progress |

## Verification
The general-call classification and the status clear can land in the same cycle, and both write gc_status. To provoke this, the bench sends a clear request and then presents the second general-call byte exactly in the cycle where gc_clr_pend is high. It judges the result by requiring that the freshly classified code survives and that gc_clr_pend still drops. A second overlap is a repeated start arriving while the recognizer is passing over an unaddressed transfer; the bench requires that the next address byte is answered afresh.

// File: rtl/i2c_recog_pkg.sv
package i2c_recog_pkg;

   localparam int ADDR_BITS = 7;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_ADDR   = 3'd1,
      ST_SLV    = 3'd2,
      ST_GCDATA = 3'd3,
      ST_PASS   = 3'd4
   } rec_state_e;

   typedef enum logic [1:0] {
      GC_NONE   = 2'b00,
      GC_RESET  = 2'b01,
      GC_REPROG = 2'b10,
      GC_HWCALL = 2'b11
   } gc_code_e;

endpackage

// File: rtl/i2c_recog_idmatch.sv
module i2c_recog_idmatch #(
   parameter int NUM_IDS = 4,
   parameter int ADDR_W  = 7
) (
   input  logic [NUM_IDS*ADDR_W-1:0] ids,
   input  logic [ADDR_W-1:0]         addr,
   output logic                      any_hit
);
   logic [NUM_IDS-1:0] hit_vec;
   logic               addr_nonzero;

   // address zero is reserved for the general call and never matches an ID
   assign addr_nonzero = (addr != '0);

   for (genvar k = 0; k < NUM_IDS; k++) begin : g_cmp
      assign hit_vec[k] = addr_nonzero && (ids[k*ADDR_W +: ADDR_W] == addr);
   end

   assign any_hit = |hit_vec;
endmodule

// File: rtl/i2c_recog_gcclass.sv
module i2c_recog_gcclass
   import i2c_recog_pkg::*;
#(
   parameter logic [7:0] RESET_CODE   = 8'h06,
   parameter logic [7:0] REPROG_CODE  = 8'h04,
   parameter bit         HWGC_SUPPORT = 1'b1
) (
   input  logic [7:0] data,
   input  logic [7:0] alt_id,
   input  logic       hwgc_en,
   output gc_code_e   code
);
   gc_code_e std_code;

   always_comb begin
      if (data == RESET_CODE)       std_code = GC_RESET;
      else if (data == REPROG_CODE) std_code = GC_REPROG;
      else                          std_code = GC_NONE;
   end

   if (HWGC_SUPPORT) begin : g_hw
      logic alt_hit;
      assign alt_hit = hwgc_en && (data == alt_id);
      assign code = (std_code == GC_NONE && alt_hit) ? GC_HWCALL : std_code;
   end else begin : g_nohw
      logic unused_hw;
      assign unused_hw = hwgc_en ^ (^alt_id);
      assign code = std_code;
   end
endmodule

// File: rtl/i2c_recog_fsm.sv
module i2c_recog_fsm
   import i2c_recog_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       slv_en,
   input  logic       gc_en,
   input  logic       start_evt,
   input  logic       stop_evt,
   input  logic       byte_vld,
   input  logic [7:0] byte_data,
   input  logic       id_hit,
   input  gc_code_e   gc_code,
   output logic       ack_vld,
   output logic       ack,
   output logic       addressed,
   output logic       is_read,
   output logic       addr_take,
   output logic       addr_rd,
   output logic       gc_take
);
   rec_state_e state_q, state_d;
   logic       read_q, read_d;
   logic       ack_vld_d, ack_d;
   logic       rw_bit;
   logic [ADDR_W-1:0] addr_field;

   assign rw_bit     = byte_data[0];
   assign addr_field = byte_data[ADDR_W:1];

   always_comb begin
      state_d   = state_q;
      read_d    = read_q;
      ack_vld_d = 1'b0;
      ack_d     = 1'b0;
      addr_take = 1'b0;
      addr_rd   = 1'b0;
      gc_take   = 1'b0;
      if (!slv_en) begin
         state_d = ST_IDLE;
         read_d  = 1'b0;
      end else if (start_evt) begin
         state_d = ST_ADDR;
         read_d  = 1'b0;
      end else if (stop_evt) begin
         state_d = ST_IDLE;
         read_d  = 1'b0;
      end else if (byte_vld) begin
         case (state_q)
            ST_ADDR: begin
               ack_vld_d = 1'b1;
               if (id_hit) begin
                  ack_d     = 1'b1;
                  addr_take = 1'b1;
                  addr_rd   = rw_bit;
                  read_d    = rw_bit;
                  state_d   = ST_SLV;
               end else if (gc_en && addr_field == '0 && !rw_bit) begin
                  ack_d     = 1'b1;
                  addr_take = 1'b1;
                  state_d   = ST_GCDATA;
               end else begin
                  state_d   = ST_PASS;
               end
            end
            ST_SLV: begin
               if (!read_q) begin
                  ack_vld_d = 1'b1;
                  ack_d     = 1'b1;
               end
            end
            ST_GCDATA: begin
               ack_vld_d = 1'b1;
               ack_d     = 1'b1;
               gc_take   = 1'b1;
               state_d   = (gc_code == GC_RESET) ? ST_IDLE : ST_PASS;
               read_d    = 1'b0;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         read_q  <= 1'b0;
         ack_vld <= 1'b0;
         ack     <= 1'b0;
      end else begin
         state_q <= state_d;
         read_q  <= read_d;
         ack_vld <= ack_vld_d;
         ack     <= ack_d;
      end
   end

   assign addressed = (state_q == ST_SLV);
   assign is_read   = read_q && addressed;
endmodule

// File: rtl/i2c_recog_flags.sv
module i2c_recog_flags
   import i2c_recog_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       slv_en,
   input  logic       stop_irq_en,
   input  logic       txreq_dis,
   input  logic       gc_clr,
   input  logic       start_evt,
   input  logic       stop_evt,
   input  logic       rw_fall,
   input  logic       addr_take,
   input  logic       addr_rd,
   input  logic       gc_take,
   input  gc_code_e   gc_code,
   output logic [1:0] gc_status,
   output logic       iface_rst,
   output logic       stop_irq,
   output logic       tx_req,
   output logic       gc_clr_pend
);
   logic armed_q;
   logic rd_pend_q;
   logic reset_take;
   logic real_stop;

   assign reset_take = gc_take && (gc_code == GC_RESET);
   assign real_stop  = slv_en && stop_evt && !start_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q     <= 1'b0;
         rd_pend_q   <= 1'b0;
         gc_status   <= GC_NONE;
         iface_rst   <= 1'b0;
         stop_irq    <= 1'b0;
         tx_req      <= 1'b0;
         gc_clr_pend <= 1'b0;
      end else begin
         // stop interrupt needs an acknowledged address since the last stop
         stop_irq <= real_stop && armed_q && stop_irq_en;
         if (!slv_en || reset_take || real_stop) armed_q <= 1'b0;
         else if (addr_take)                     armed_q <= 1'b1;

         // transmit-data request once per acknowledged read address
         tx_req <= slv_en && rw_fall && rd_pend_q && !txreq_dis;
         if (!slv_en || start_evt || stop_evt || rw_fall) rd_pend_q <= 1'b0;
         else if (addr_take && addr_rd)                   rd_pend_q <= 1'b1;

         iface_rst   <= reset_take;
         gc_clr_pend <= gc_clr;

         // a new classification outranks the pending clear
         if (gc_take && gc_code != GC_NONE) gc_status <= gc_code;
         else if (gc_clr_pend)              gc_status <= GC_NONE;
      end
   end
endmodule

// File: rtl/i2c_slave_recog.sv
module i2c_slave_recog
   import i2c_recog_pkg::*;
#(
   parameter int         NUM_IDS      = 4,
   parameter int         ADDR_W       = i2c_recog_pkg::ADDR_BITS,
   parameter logic [7:0] RESET_CODE   = 8'h06,
   parameter logic [7:0] REPROG_CODE  = 8'h04,
   parameter bit         HWGC_SUPPORT = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      slv_en,
   input  logic                      gc_en,
   input  logic                      hwgc_en,
   input  logic                      stop_irq_en,
   input  logic                      txreq_dis,
   input  logic                      gc_clr,
   input  logic [NUM_IDS*ADDR_W-1:0] slv_ids,
   input  logic [7:0]                alt_id,
   input  logic                      start_evt,
   input  logic                      stop_evt,
   input  logic                      byte_vld,
   input  logic [7:0]                byte_data,
   input  logic                      rw_fall,
   output logic                      ack_vld,
   output logic                      ack,
   output logic                      addressed,
   output logic                      is_read,
   output logic [1:0]                gc_status,
   output logic                      iface_rst,
   output logic                      stop_irq,
   output logic                      tx_req,
   output logic                      gc_clr_pend
);
   localparam int IDS_W = NUM_IDS * ADDR_W;

   if (NUM_IDS < 1 || NUM_IDS > 8) begin : g_bad_ids
      $error("NUM_IDS must lie in 1..8");
   end
   if (ADDR_W != 7) begin : g_bad_aw
      $error("ADDR_W must be 7");
   end
   if (RESET_CODE[0] || REPROG_CODE[0] || RESET_CODE == REPROG_CODE) begin : g_bad_codes
      $error("command codes must be distinct with LSB 0");
   end

   logic     id_hit;
   logic     addr_take, addr_rd, gc_take;
   gc_code_e gc_code;

   i2c_recog_idmatch #(.NUM_IDS(NUM_IDS), .ADDR_W(ADDR_W)) i_idmatch (
      .ids     (slv_ids[IDS_W-1:0]),
      .addr    (byte_data[ADDR_W:1]),
      .any_hit (id_hit)
   );

   i2c_recog_gcclass #(
      .RESET_CODE   (RESET_CODE),
      .REPROG_CODE  (REPROG_CODE),
      .HWGC_SUPPORT (HWGC_SUPPORT)
   ) i_gcclass (
      .data    (byte_data),
      .alt_id  (alt_id),
      .hwgc_en (hwgc_en),
      .code    (gc_code)
   );

   i2c_recog_fsm #(.ADDR_W(ADDR_W)) i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .slv_en    (slv_en),
      .gc_en     (gc_en),
      .start_evt (start_evt),
      .stop_evt  (stop_evt),
      .byte_vld  (byte_vld),
      .byte_data (byte_data),
      .id_hit    (id_hit),
      .gc_code   (gc_code),
      .ack_vld   (ack_vld),
      .ack       (ack),
      .addressed (addressed),
      .is_read   (is_read),
      .addr_take (addr_take),
      .addr_rd   (addr_rd),
      .gc_take   (gc_take)
   );

   i2c_recog_flags i_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .slv_en      (slv_en),
      .stop_irq_en (stop_irq_en),
      .txreq_dis   (txreq_dis),
      .gc_clr      (gc_clr),
      .start_evt   (start_evt),
      .stop_evt    (stop_evt),
      .rw_fall     (rw_fall),
      .addr_take   (addr_take),
      .addr_rd     (addr_rd),
      .gc_take     (gc_take),
      .gc_code     (gc_code),
      .gc_status   (gc_status),
      .iface_rst   (iface_rst),
      .stop_irq    (stop_irq),
      .tx_req      (tx_req),
      .gc_clr_pend (gc_clr_pend)
   );
endmodule

// File: rtl/i2c_slave_recog_chk.sv
module i2c_slave_recog_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       slv_en,
   input logic       stop_irq_en,
   input logic       txreq_dis,
   input logic       gc_clr,
   input logic       stop_evt,
   input logic       byte_vld,
   input logic       rw_fall,
   input logic       ack_vld,
   input logic       ack,
   input logic       addressed,
   input logic       is_read,
   input logic [1:0] gc_status,
   input logic       iface_rst,
   input logic       stop_irq,
   input logic       tx_req,
   input logic       gc_clr_pend
);
   p_quiet_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !slv_en |=> !ack_vld && !stop_irq && !tx_req && !iface_rst);

   p_stop_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stop_irq |-> $past(stop_evt) && $past(stop_irq_en));

   p_txreq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |-> $past(rw_fall) && !$past(txreq_dis));

   p_read_selected_r8: assert property (@(posedge clk) disable iff (!rst_n)
      is_read |-> addressed);

   p_rst_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      iface_rst |-> gc_status == 2'b01);

   p_ack_cause_r13: assert property (@(posedge clk) disable iff (!rst_n)
      ack_vld |-> $past(byte_vld));

   p_ack_only_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> ack_vld);

   p_clr_self_r9: assert property (@(posedge clk) disable iff (!rst_n)
      gc_clr_pend && !gc_clr |=> !gc_clr_pend);
endmodule

bind i2c_slave_recog i2c_slave_recog_chk i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .slv_en      (slv_en),
   .stop_irq_en (stop_irq_en),
   .txreq_dis   (txreq_dis),
   .gc_clr      (gc_clr),
   .stop_evt    (stop_evt),
   .byte_vld    (byte_vld),
   .rw_fall     (rw_fall),
   .ack_vld     (ack_vld),
   .ack         (ack),
   .addressed   (addressed),
   .is_read     (is_read),
   .gc_status   (gc_status),
   .iface_rst   (iface_rst),
   .stop_irq    (stop_irq),
   .tx_req      (tx_req),
   .gc_clr_pend (gc_clr_pend)
);

// File: tb/test_i2c_slave_recog.sv
`timescale 1ns/1ps
module test_i2c_slave_recog;
   localparam int NUM_IDS = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic slv_en = 1'b0, gc_en = 1'b0, hwgc_en = 1'b0, stop_irq_en = 1'b0;
   logic txreq_dis = 1'b0, gc_clr = 1'b0;
   logic [NUM_IDS*7-1:0] slv_ids;
   logic [7:0] alt_id = 8'h5B;
   logic start_evt = 1'b0, stop_evt = 1'b0, byte_vld = 1'b0, rw_fall = 1'b0;
   logic [7:0] byte_data = 8'h00;
   logic ack_vld, ack, addressed, is_read, iface_rst, stop_irq, tx_req, gc_clr_pend;
   logic [1:0] gc_status;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   // IDs: 0x50, 0x51, 0x2A, 0x13 (ID0 in the low bits)
   assign slv_ids = {7'h13, 7'h2A, 7'h51, 7'h50};

   always #2 clk = ~clk;

   i2c_slave_recog #(.NUM_IDS(NUM_IDS)) i_i2c_slave_recog (
      .clk(clk), .rst_n(rst_n), .slv_en(slv_en), .gc_en(gc_en), .hwgc_en(hwgc_en),
      .stop_irq_en(stop_irq_en), .txreq_dis(txreq_dis), .gc_clr(gc_clr),
      .slv_ids(slv_ids), .alt_id(alt_id), .start_evt(start_evt), .stop_evt(stop_evt),
      .byte_vld(byte_vld), .byte_data(byte_data), .rw_fall(rw_fall),
      .ack_vld(ack_vld), .ack(ack), .addressed(addressed), .is_read(is_read),
      .gc_status(gc_status), .iface_rst(iface_rst), .stop_irq(stop_irq),
      .tx_req(tx_req), .gc_clr_pend(gc_clr_pend)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // all stimulus tasks start and end at a falling edge
   task automatic do_start();
      start_evt = 1'b1; @(negedge clk); start_evt = 1'b0;
   endtask
   task automatic do_stop();
      stop_evt = 1'b1; @(negedge clk); stop_evt = 1'b0;
   endtask
   task automatic do_byte(input logic [7:0] b);
      byte_data = b; byte_vld = 1'b1; @(negedge clk); byte_vld = 1'b0;
   endtask
   task automatic do_rwfall();
      rw_fall = 1'b1; @(negedge clk); rw_fall = 1'b0;
   endtask
   task automatic do_clear();
      gc_clr = 1'b1; @(negedge clk); gc_clr = 1'b0;
      chk("R9 pend high", gc_clr_pend, 1);
      @(negedge clk);
      chk("R9 status cleared", gc_status, 0);
      chk("R9 pend dropped", gc_clr_pend, 0);
   endtask

   task automatic t_reset();
      chk("R12 ack_vld", ack_vld, 0);
      chk("R12 ack", ack, 0);
      chk("R12 addressed", addressed, 0);
      chk("R12 is_read", is_read, 0);
      chk("R12 gc_status", gc_status, 0);
      chk("R12 pulses", {iface_rst, stop_irq, tx_req, gc_clr_pend}, 0);
   endtask

   task automatic t_id_write();
      do_start();
      do_byte(8'h54);
      chk("R1 ack_vld id2", ack_vld, 1);
      chk("R1 ack id2", ack, 1);
      chk("R1 addressed", addressed, 1);
      chk("R1 not read", is_read, 0);
      do_byte(8'h99);
      chk("R13 write data ack", {ack_vld, ack}, 2'b11);
      do_start();
      do_byte(8'h26);
      chk("R1 id3 ack", {ack_vld, ack, addressed}, 3'b111);
      do_stop();
      chk("R11 stop deselects", addressed, 0);
      do_byte(8'h26);
      chk("R11 idle byte ignored", ack_vld, 0);
   endtask

   task automatic t_nomatch();
      do_start();
      do_byte(8'hEE);
      chk("R2 nack", {ack_vld, ack, addressed}, 3'b100);
      do_byte(8'h12);
      chk("R2 data ignored", ack_vld, 0);
      do_stop();
   endtask

   task automatic t_gc_addr();
      gc_en = 1'b1;
      do_start(); do_byte(8'h00);
      chk("R3 gc acked", {ack_vld, ack, addressed}, 3'b110);
      do_start(); do_byte(8'h01);
      chk("R3 gc read nack", {ack_vld, ack}, 2'b10);
      gc_en = 1'b0;
      do_start(); do_byte(8'h00);
      chk("R3 gc disabled nack", {ack_vld, ack}, 2'b10);
      do_stop();
   endtask

   task automatic t_gc_reset();
      gc_en = 1'b1;
      do_start(); do_byte(8'h00); do_byte(8'h06);
      chk("R4 ack", {ack_vld, ack}, 2'b11);
      chk("R4 status", gc_status, 2'b01);
      chk("R4 iface_rst", iface_rst, 1);
      @(negedge clk);
      chk("R4 pulse one cycle", iface_rst, 0);
      do_byte(8'h54);
      chk("R4 idle after reset", ack_vld, 0);
      do_clear();
   endtask

   task automatic t_gc_reprog();
      gc_en = 1'b1;
      do_start(); do_byte(8'h00); do_byte(8'h04);
      chk("R5 status", gc_status, 2'b10);
      chk("R5 no iface_rst", iface_rst, 0);
      do_byte(8'h54);
      chk("R5 later byte ignored", ack_vld, 0);
      do_stop();
      do_clear();
   endtask

   task automatic t_hwgc();
      gc_en = 1'b1; hwgc_en = 1'b1;
      do_start(); do_byte(8'h00); do_byte(8'h5B);
      chk("R6 hw call", gc_status, 2'b11);
      do_stop();
      do_clear();
      hwgc_en = 1'b0;
      do_start(); do_byte(8'h00); do_byte(8'h5B);
      chk("R6 hw disabled", gc_status, 2'b00);
      do_stop();
   endtask

   task automatic t_stop_irq();
      stop_irq_en = 1'b1;
      do_start(); do_byte(8'hA0); do_stop();
      chk("R7 irq after match", stop_irq, 1);
      @(negedge clk);
      chk("R7 irq one cycle", stop_irq, 0);
      do_start(); do_byte(8'hEE); do_stop();
      chk("R7 no irq unmatched", stop_irq, 0);
      stop_irq_en = 1'b0;
      do_start(); do_byte(8'hA0); do_stop();
      chk("R7 no irq disabled", stop_irq, 0);
   endtask

   task automatic t_txreq();
      do_start(); do_byte(8'h55);
      chk("R8 read selected", {addressed, is_read}, 2'b11);
      do_rwfall();
      chk("R8 tx_req", tx_req, 1);
      do_byte(8'h00);
      chk("R13 read data no ack", ack_vld, 0);
      txreq_dis = 1'b1;
      do_start(); do_byte(8'h55); do_rwfall();
      chk("R8 tx_req disabled", tx_req, 0);
      txreq_dis = 1'b0;
      do_start(); do_byte(8'h54); do_rwfall();
      chk("R8 no tx_req on write", tx_req, 0);
      do_stop();
   endtask

   task automatic t_clear_collide();
      gc_en = 1'b1;
      do_start(); do_byte(8'h00); do_byte(8'h06);
      do_start(); do_byte(8'h00);
      gc_clr = 1'b1; @(negedge clk); gc_clr = 1'b0;
      do_byte(8'h04);
      chk("R9 new code wins", gc_status, 2'b10);
      chk("R9 pend dropped", gc_clr_pend, 0);
      do_stop();
      do_clear();
   endtask

   task automatic t_disabled();
      slv_en = 1'b0; gc_en = 1'b1; stop_irq_en = 1'b1;
      do_start(); do_byte(8'h54);
      chk("R10 no ack", ack_vld, 0);
      do_start(); do_byte(8'h00); do_byte(8'h06);
      chk("R10 status kept", gc_status, 0);
      chk("R10 no iface_rst", iface_rst, 0);
      do_stop();
      chk("R10 no stop_irq", stop_irq, 0);
      slv_en = 1'b1; stop_irq_en = 1'b0;
   endtask

   task automatic t_restart();
      do_start(); do_byte(8'hEE);
      do_start(); do_byte(8'hA2);
      chk("R11 repeated start readdress", {ack_vld, ack, addressed}, 3'b111);
      do_stop();
   endtask

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      slv_en = 1'b1;
      t_id_write();
      t_nomatch();
      t_gc_addr();
      t_gc_reset();
      t_gc_reprog();
      t_hwgc();
      t_stop_irq();
      t_txreq();
      t_clear_collide();
      t_restart();
      t_disabled();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL R12 watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end
endmodule